// File: doc/BRIEF.md
# Feedback-Triggered Fixed-On-Time Pulse Controller

This block produces the gate drive of a load-driven switching regulator without any free-running oscillator. A comparator elsewhere reports that the regulated output has dropped below its target. When that flag is high and the controller is idle, the block opens one gate pulse. The pulse lasts a fixed maximum number of clock ticks. A mandatory low interval always follows it. If the flag is still high when that interval ends, the next pulse begins at once. The switching rate therefore follows the load: it reaches its highest value under continuous demand and drops to nothing at no load.

An over-current flag can end a pulse early. The flag is ignored during a short blanking window after the gate rises, so that the turn-on current spike does not trip it. The length of the low interval is supplied from outside on each cycle, for example by an overload guard that stretches it. It is sampled on the clock edge where the gate falls and is never allowed below a configured floor. When a pulse ends, the number of ticks the gate was high is published together with a one-cycle strobe. An enable from the protection logic forces the gate low and returns the controller to idle. Every duration is counted in system clock ticks.

Top module: `fbpulse_ctrl`

## Requirements
- R1: With `en` high and the controller idle, a clock edge that samples `fb_low` high raises `gate` on that edge. While idle with `fb_low` low, `gate` stays low.
- R2: Without a qualifying over-current, `gate` stays high for exactly `TON_MAX` clock cycles.
- R3: After every pulse, `gate` stays low for max(`off_len`, `TOFF_MIN`) cycles. `off_len` is an unsigned count sampled on the edge where `gate` falls; later changes do not affect the current interval.
- R4: If `ocp` is sampled high at the end of high cycle k, with k > `TBLANK` (cycles numbered from 1), `gate` falls on that edge and the pulse lasts k cycles.
- R5: An `ocp` sampled high during high cycles 1 to `TBLANK` is ignored, and the pulse continues.
- R6: If `fb_low` is high in the last cycle of the low interval, the next pulse starts on the following edge. Otherwise `gate` stays low until an edge samples `fb_low` high.
- R7: With `fb_low` held high and `off_len` <= `TOFF_MIN`, consecutive rising edges of `gate` are exactly `TON_MAX + TOFF_MIN` cycles apart.
- R8: An edge that samples `en` low drives `gate` low and returns to idle. An aborted pulse raises no `done` and leaves `on_ticks` unchanged. `gate` stays low while `en` is low.
- R9: `done` is high for exactly one cycle, namely the first cycle in which `gate` is low after a completed pulse. `on_ticks` then holds the number of cycles the gate was high, and keeps that value until the next completed pulse.
- R10: While `rst` is high, and after it is released, `gate`, `done` and `on_ticks` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Switching permitted by the protection logic |
| fb_low | input | 1 | Output below target; requests a pulse |
| ocp | input | 1 | Switch current above limit |
| off_len | input | OFFW | Requested low-interval length in ticks |
| gate | output | 1 | Registered gate drive |
| done | output | 1 | One-cycle strobe at the end of a completed pulse |
| on_ticks | output | CNTW | High duration of the last completed pulse |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the over-current cut and the maximum-on timeout. The bench sweeps the cycle in which `ocp` is raised across every high cycle, including the final one where the timeout also ends the pulse. In that case there must be a single falling edge and a single strobe reporting `TON_MAX`, and the cycles at and just past the blanking boundary must land on opposite sides of the R4/R5 split. The second pair is the end of the low interval and the re-arming decision, where `off_len` is altered after it has been sampled. Each expected high and low length is computed arithmetically from the parameters and compared with the counts observed at the ports.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2
  } phase_t;
endpackage

// File: rtl/fbp_on_timer.sv
// Counts high ticks of the current pulse and qualifies the current limit
// against the blanking window.
module fbp_on_timer #(
  parameter int TON_MAX = 6,
  parameter int TBLANK  = 2,
  localparam int CNTW   = $clog2(TON_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            active,
  input  logic            ocp,
  output logic [CNTW-1:0] cnt,
  output logic            at_max,
  output logic            oc_hit
);
  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (start)
      cnt <= CNTW'(1);
    else if (active && cnt != CNTW'(TON_MAX))
      cnt <= cnt + 1'b1;
  end

  assign at_max = active && (cnt == CNTW'(TON_MAX));

  generate
    if (TBLANK == 0) begin : g_noblank
      assign oc_hit = active && ocp;
    end else begin : g_blank
      assign oc_hit = active && ocp && (cnt > CNTW'(TBLANK));
    end
  endgenerate

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt != '0 && cnt <= CNTW'(TON_MAX)));
endmodule

// File: rtl/fbp_off_timer.sv
// Holds the sampled low-interval span and signals its expiry.
module fbp_off_timer #(
  parameter int TOFF_MIN = 3,
  parameter int OFFW     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic            active,
  input  logic [OFFW-1:0] len,
  output logic            expire
);
  logic [OFFW-1:0] span, cnt, span_d;

  assign span_d = (len < OFFW'(TOFF_MIN)) ? OFFW'(TOFF_MIN) : len;

  always_ff @(posedge clk) begin
    if (rst) begin
      span <= OFFW'(TOFF_MIN);
      cnt  <= '0;
    end else if (load) begin
      span <= span_d;
      cnt  <= OFFW'(1);
    end else if (active && cnt != span) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expire = active && (cnt == span);

  // R3
  span_floor_chk: assert property (@(posedge clk) disable iff (rst)
    active |-> (span >= OFFW'(TOFF_MIN) && cnt != '0));

  // R3
  span_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !load) |=> (span == $past(span)));
endmodule

// File: rtl/fbp_sequencer.sv
// Phase control, registered gate, strobe and duration report.
module fbp_sequencer
  import fbp_pkg::*;
#(
  parameter int TON_MAX = 6,
  parameter int TBLANK  = 2,
  localparam int CNTW   = $clog2(TON_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            fb_low,
  input  logic            ocp,
  input  logic [CNTW-1:0] on_cnt,
  input  logic            at_max,
  input  logic            oc_hit,
  input  logic            off_expire,
  output logic            start_on,
  output logic            end_on,
  output logic            in_on,
  output logic            in_off,
  output logic            gate,
  output logic            done,
  output logic [CNTW-1:0] on_ticks
);
  phase_t phase;
  logic   from_idle, rearm;

  always_comb begin
    from_idle = (phase == PH_IDLE);
    rearm     = (phase == PH_OFF) && off_expire;
    start_on  = en && fb_low && (from_idle || rearm);
    end_on    = en && (phase == PH_ON) && (at_max || oc_hit);
    in_on     = (phase == PH_ON);
    in_off    = (phase == PH_OFF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      gate     <= 1'b0;
      done     <= 1'b0;
      on_ticks <= '0;
    end else begin
      done <= 1'b0;
      if (!en) begin
        phase <= PH_IDLE;
        gate  <= 1'b0;
      end else if (start_on) begin
        phase <= PH_ON;
        gate  <= 1'b1;
      end else if (end_on) begin
        phase    <= PH_OFF;
        gate     <= 1'b0;
        done     <= 1'b1;
        on_ticks <= on_cnt;
      end else if (rearm) begin
        phase <= PH_IDLE;
      end
    end
  end

  // R1
  launch_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && en && fb_low) |=> gate);

  // R2
  max_on_chk: assert property (@(posedge clk) disable iff (rst)
    (gate && on_cnt == CNTW'(TON_MAX)) |=> !gate);

  // R4
  cut_chk: assert property (@(posedge clk) disable iff (rst)
    (gate && ocp && on_cnt > CNTW'(TBLANK)) |=> !gate);

  // R5
  blank_chk: assert property (@(posedge clk) disable iff (rst)
    (gate && en && on_cnt <= CNTW'(TBLANK) && on_cnt != CNTW'(TON_MAX)) |=> gate);

  // R3
  hold_low_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OFF && !off_expire) |=> !gate);

  // R8
  disable_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!gate && !done));

  // R9
  strobe_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(gate));

  // R9
  strobe_once_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/fbpulse_ctrl.sv
module fbpulse_ctrl #(
  parameter int TON_MAX  = 6,
  parameter int TBLANK   = 2,
  parameter int TOFF_MIN = 3,
  parameter int OFFW     = 4,
  localparam int CNTW    = $clog2(TON_MAX + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            fb_low,
  input  logic            ocp,
  input  logic [OFFW-1:0] off_len,
  output logic            gate,
  output logic            done,
  output logic [CNTW-1:0] on_ticks
);
  logic [CNTW-1:0] on_cnt;
  logic            at_max, oc_hit, off_expire;
  logic            start_on, end_on, in_on, in_off;

  fbp_on_timer #(.TON_MAX(TON_MAX), .TBLANK(TBLANK)) u_on (
    .clk    (clk),
    .rst    (rst),
    .start  (start_on),
    .active (in_on),
    .ocp    (ocp),
    .cnt    (on_cnt),
    .at_max (at_max),
    .oc_hit (oc_hit)
  );

  fbp_off_timer #(.TOFF_MIN(TOFF_MIN), .OFFW(OFFW)) u_off (
    .clk    (clk),
    .rst    (rst),
    .load   (end_on),
    .active (in_off),
    .len    (off_len),
    .expire (off_expire)
  );

  fbp_sequencer #(.TON_MAX(TON_MAX), .TBLANK(TBLANK)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .fb_low     (fb_low),
    .ocp        (ocp),
    .on_cnt     (on_cnt),
    .at_max     (at_max),
    .oc_hit     (oc_hit),
    .off_expire (off_expire),
    .start_on   (start_on),
    .end_on     (end_on),
    .in_on      (in_on),
    .in_off     (in_off),
    .gate       (gate),
    .done       (done),
    .on_ticks   (on_ticks)
  );
endmodule

// File: tb/tb_fbpulse_ctrl.sv
module tb_fbpulse_ctrl;
  localparam int TON_MAX  = 6;
  localparam int TBLANK   = 2;
  localparam int TOFF_MIN = 3;
  localparam int OFFW     = 4;
  localparam int CNTW     = $clog2(TON_MAX + 1);

  logic            clk = 1'b0;
  logic            rst, en, fb_low, ocp;
  logic [OFFW-1:0] off_len;
  logic            gate, done;
  logic [CNTW-1:0] on_ticks;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fbpulse_ctrl #(.TON_MAX(TON_MAX), .TBLANK(TBLANK), .TOFF_MIN(TOFF_MIN), .OFFW(OFFW)) dut (
    .clk(clk), .rst(rst), .en(en), .fb_low(fb_low), .ocp(ocp),
    .off_len(off_len), .gate(gate), .done(done), .on_ticks(on_ticks)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
    end
  endtask

  function automatic int exp_high(input int k);
    if (k > TBLANK && k < TON_MAX) return k;
    return TON_MAX;
  endfunction

  function automatic int exp_low(input int len);
    return (len < TOFF_MIN) ? TOFF_MIN : len;
  endfunction

  // Wait until gate is sampled low (pulse ended); returns observed high cycles.
  task automatic wait_fall(output int h);
    h = 0;
    while (gate && h < 40) begin
      @(negedge clk);
      h++;
    end
  endtask

  // Sweep: current limit in high cycle k, low interval request len.
  task automatic run_pulse(input int k, input int len);
    int h;
    int l;
    int prev_ticks;
    bit quiet;
    fb_low  = 1'b1;
    off_len = OFFW'(len);
    ocp     = 1'b0;
    @(negedge clk);
    chk(gate == 1'b1, "R1 launch", int'(gate), 1);
    h = 1;
    while (h < 40) begin
      ocp = (h == k);
      @(negedge clk);
      if (gate) h++;
      else break;
    end
    ocp = 1'b0;
    // R2 / R4 / R5 pulse length
    chk(h == exp_high(k), (k <= TBLANK) ? "R5 blanked length" :
        (k < TON_MAX) ? "R4 cut length" : "R2 full length", h, exp_high(k));
    chk(done == 1'b1, "R9 strobe", int'(done), 1);
    chk(int'(on_ticks) == exp_high(k), "R9 on_ticks", int'(on_ticks), exp_high(k));
    prev_ticks = int'(on_ticks);
    off_len = ~OFFW'(len);  // must not alter the running interval (R3)
    l = 1;
    quiet = 1'b1;
    while (l < 40) begin
      @(negedge clk);
      if (done) quiet = 1'b0;
      if (!gate) l++;
      else break;
    end
    chk(quiet, "R9 strobe single cycle", int'(quiet), 1);
    // R3 and R6: low length then immediate relaunch
    chk(l == exp_low(len), "R3 low interval", l, exp_low(len));
    chk(gate == 1'b1, "R6 relaunch", int'(gate), 1);
    en = 1'b0;
    @(negedge clk);
    chk(gate == 1'b0 && done == 1'b0, "R8 abort", int'({gate, done}), 0);
    chk(int'(on_ticks) == prev_ticks, "R8 on_ticks kept", int'(on_ticks), prev_ticks);
    fb_low = 1'b0;
    en = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int h;
    int per;
    bit stayed;
    rst = 1'b1; en = 1'b1; fb_low = 1'b0; ocp = 1'b0; off_len = '0;
    repeat (3) @(negedge clk);
    // R10 reset state with fb_low requested
    fb_low = 1'b1;
    @(negedge clk);
    chk(gate == 1'b0 && done == 1'b0 && on_ticks == '0, "R10 reset",
        int'({gate, done, on_ticks}), 0);
    fb_low = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(gate == 1'b0 && done == 1'b0 && on_ticks == '0, "R10 after release",
        int'({gate, done, on_ticks}), 0);

    // R1 idle with fb_low low
    stayed = 1'b1;
    repeat (8) begin
      @(negedge clk);
      if (gate) stayed = 1'b0;
    end
    chk(stayed, "R1 idle holds low", int'(stayed), 1);

    // Sweep of current-limit position and low-interval request
    for (int k = 1; k <= TON_MAX + 1; k++)
      for (int len = 0; len < (1 << OFFW); len++)
        run_pulse(k, len);

    // R6: fb_low low at end of interval keeps gate low until it rises
    fb_low = 1'b1; off_len = '0;
    @(negedge clk);
    fb_low = 1'b0;
    wait_fall(h);
    stayed = 1'b1;
    repeat (15) begin
      @(negedge clk);
      if (gate) stayed = 1'b0;
    end
    chk(stayed, "R6 waits for demand", int'(stayed), 1);
    fb_low = 1'b1;
    @(negedge clk);
    chk(gate == 1'b1, "R6 launch on demand", int'(gate), 1);

    // R7: continuous demand gives the top rate
    for (int p = 0; p < 3; p++) begin
      per = 0;
      while (gate && per < 40) begin @(negedge clk); per++; end
      while (!gate && per < 40) begin @(negedge clk); per++; end
      chk(per == TON_MAX + TOFF_MIN, "R7 period", per, TON_MAX + TOFF_MIN);
    end

    // R8: disable during the low interval, then recover
    wait_fall(h);
    en = 1'b0;
    stayed = 1'b1;
    repeat (6) begin
      @(negedge clk);
      if (gate || done) stayed = 1'b0;
    end
    chk(stayed, "R8 held low while disabled", int'(stayed), 1);
    en = 1'b1;
    @(negedge clk);
    chk(gate == 1'b1, "R8 resumes from idle", int'(gate), 1);
    fb_low = 1'b0;
    wait_fall(h);
    chk(h == TON_MAX, "R2 after resume", h, TON_MAX);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule